// File: doc/BRIEF.md
# Four-Contestant Quiz Buzzer Controller

This block runs one game of a quiz for four contestants and a host. The contestants' buzzers arrive as clean single-cycle pulses. The first contestant to buzz takes the round. That contestant's indicator lights, and every other buzzer is locked out until the host re-arms the block.

Taking a round opens a timed answer window, counted in one-second tick pulses. While the window is open the host can raise or lower the winner's score by one point at a time. Each score stays between 0 and 9. A three-colour status output shows green when the block is idle, blue while the window is open and red once the window has run out. The winner's score is driven out as a BCD digit, ready for an external seven-segment decoder. A new-game pulse resets every score to the starting value.

Top module: `quiz_buzzer_ctrl`

## Requirements
- R1: When no round is held, the first cycle with a nonzero `buzz` sets `winner` to a one-hot code at the next clock edge, with bit i standing for contestant i. Later buzzes leave `winner` unchanged until `rearm`.
- R2: If several `buzz` bits are set in the cycle that takes the round, the lowest-numbered contestant wins.
- R3: `rearm` clears `winner` to 0 at the next edge and returns the status output to green. A buzz in the same cycle as `rearm` is ignored.
- R4: While the window is open, `inc` adds 1 to the winner's score and `dec` subtracts 1, effective at the next edge. If both are high in one cycle, the score does not change.
- R5: Scores saturate. `inc` at 9 leaves 9, and `dec` at 0 leaves 0.
- R6: Reset and `new_game` load every score with 5. `new_game` overrides `inc` and `dec` in the same cycle.
- R7: Taking a round zeroes the window count. A tick in that same cycle is not counted. The status is blue while fewer than 30 ticks have been counted. From the edge that counts the 30th tick, the status is red until `rearm`.
- R8: Ticks that arrive while no round is held have no effect on a later window.
- R9: `inc` and `dec` change no score while idle or after the window has expired.
- R10: `score_bcd` shows the winner's score, or 0 when no round is held. `rearm` changes no score.
- R11: `status_rgb` is one-hot: bit 2 is red, bit 1 is green and bit 0 is blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buzz | input | 4 | Contestant buzzer pulses, bit i = contestant i |
| rearm | input | 1 | Host pulse that ends the round |
| new_game | input | 1 | Reloads all scores with 5 |
| inc | input | 1 | Add one point to the winner |
| dec | input | 1 | Remove one point from the winner |
| tick | input | 1 | One-second enable pulse |
| winner | output | 4 | One-hot winner indicator |
| status_rgb | output | 3 | One-hot colour: [2] red, [1] green, [0] blue |
| score_bcd | output | 4 | Winner's score, or 0 when idle |

## Verification
A corrupted arbitration register shows at once on `winner` and `status_rgb`, one edge after the buzz that caused it. A wrong window count stays hidden until the status turns red one tick too early or too late. The bench therefore walks every one of the 30 ticks and compares the colour after each one. A wrong score register shows only when that contestant next holds a round, so every score check takes the round first and compares `score_bcd` after each point change. Saturation is driven past both ends of the range.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int SCORE_W = 4;
  typedef logic [SCORE_W-1:0] score_t;

  localparam logic [2:0] RGB_RED   = 3'b100;
  localparam logic [2:0] RGB_GREEN = 3'b010;
  localparam logic [2:0] RGB_BLUE  = 3'b001;

  typedef enum logic [1:0] {PH_IDLE, PH_OPEN, PH_LATE} phase_e;

  function automatic score_t sat_step(input score_t v, input logic up,
                                      input score_t top);
    if (up) return (v >= top) ? top : v + score_t'(1);
    return (v == '0) ? v : v - score_t'(1);
  endfunction
endpackage

// File: rtl/quiz_arbiter.sv
module quiz_arbiter #(
  parameter int N_PLAYERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_PLAYERS-1:0] buzz,
  input  logic                 rearm,
  output logic [N_PLAYERS-1:0] winner,
  output logic                 grant_evt
);
  logic [N_PLAYERS-1:0] lowest;

  assign lowest    = buzz & (~buzz + N_PLAYERS'(1));
  assign grant_evt = ~|winner & |buzz & ~rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         winner <= '0;
    else if (rearm)     winner <= '0;
    else if (grant_evt) winner <= lowest;
  end
endmodule

// File: rtl/quiz_window.sv
module quiz_window #(
  parameter int TICKS = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       clear,
  input  logic                       holding,
  input  logic                       tick,
  output logic                       expired,
  output logic [$clog2(TICKS+1)-1:0] count
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (start || clear) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (holding && !expired && tick) begin
      if (count == LAST) begin
        count   <= '0;
        expired <= 1'b1;
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/quiz_score_bank.sv
module quiz_score_bank
  import quiz_pkg::*;
#(
  parameter int N_PLAYERS  = 4,
  parameter int SCORE_INIT = 5,
  parameter int SCORE_MAX  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 new_game,
  input  logic                 enable,
  input  logic [N_PLAYERS-1:0] winner,
  input  logic                 inc,
  input  logic                 dec,
  output score_t               score_sel
);
  localparam score_t INIT_V = score_t'(SCORE_INIT);
  localparam score_t MAX_V  = score_t'(SCORE_MAX);

  score_t score_q [N_PLAYERS];
  logic   adjust;

  assign adjust = enable & (inc ^ dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PLAYERS; i++) score_q[i] <= INIT_V;
    end else if (new_game) begin
      for (int i = 0; i < N_PLAYERS; i++) score_q[i] <= INIT_V;
    end else if (adjust) begin
      for (int i = 0; i < N_PLAYERS; i++)
        if (winner[i]) score_q[i] <= sat_step(score_q[i], inc, MAX_V);
    end
  end

  always_comb begin
    score_sel = '0;
    for (int i = 0; i < N_PLAYERS; i++)
      if (winner[i]) score_sel = score_sel | score_q[i];
  end
endmodule

// File: rtl/quiz_buzzer_ctrl.sv
module quiz_buzzer_ctrl
  import quiz_pkg::*;
#(
  parameter int N_PLAYERS    = 4,
  parameter int WINDOW_TICKS = 30,
  parameter int SCORE_INIT   = 5,
  parameter int SCORE_MAX    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_PLAYERS-1:0] buzz,
  input  logic                 rearm,
  input  logic                 new_game,
  input  logic                 inc,
  input  logic                 dec,
  input  logic                 tick,
  output logic [N_PLAYERS-1:0] winner,
  output logic [2:0]           status_rgb,
  output logic [SCORE_W-1:0]   score_bcd
);
  localparam int CNT_W = $clog2(WINDOW_TICKS + 1);

  logic             grant_evt;
  logic             holding;
  logic             expired;
  logic [CNT_W-1:0] win_count;
  phase_e           phase;

  quiz_arbiter #(.N_PLAYERS(N_PLAYERS)) u_arb (
    .clk(clk), .rst_n(rst_n), .buzz(buzz), .rearm(rearm),
    .winner(winner), .grant_evt(grant_evt)
  );

  assign holding = |winner;

  quiz_window #(.TICKS(WINDOW_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .start(grant_evt), .clear(rearm),
    .holding(holding), .tick(tick), .expired(expired), .count(win_count)
  );

  quiz_score_bank #(
    .N_PLAYERS(N_PLAYERS), .SCORE_INIT(SCORE_INIT), .SCORE_MAX(SCORE_MAX)
  ) u_score (
    .clk(clk), .rst_n(rst_n), .new_game(new_game),
    .enable(holding & ~expired), .winner(winner),
    .inc(inc), .dec(dec), .score_sel(score_bcd)
  );

  always_comb begin
    if (!holding)     phase = PH_IDLE;
    else if (expired) phase = PH_LATE;
    else              phase = PH_OPEN;
    case (phase)
      PH_OPEN: status_rgb = RGB_BLUE;
      PH_LATE: status_rgb = RGB_RED;
      default: status_rgb = RGB_GREEN;
    endcase
  end
endmodule

// File: rtl/quiz_buzzer_chk.sv
module quiz_buzzer_chk #(
  parameter int N_PLAYERS    = 4,
  parameter int WINDOW_TICKS = 30,
  parameter int SCORE_MAX    = 9,
  parameter int CNT_W        = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_PLAYERS-1:0] buzz,
  input logic                 rearm,
  input logic                 new_game,
  input logic [N_PLAYERS-1:0] winner,
  input logic [2:0]           status_rgb,
  input logic [3:0]           score_bcd,
  input logic [CNT_W-1:0]     win_count
);
  AST_WINNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner)); // R1
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (winner != '0 && !rearm) |=> winner == $past(winner)); // R1
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> winner == '0); // R3
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(status_rgb)); // R11
  AST_IDLE_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == '0) |-> status_rgb == 3'b010); // R11
  AST_SCORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    score_bcd <= 4'(SCORE_MAX)); // R5
  AST_RED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rgb == 3'b100 && !rearm) |=> status_rgb == 3'b100); // R7
  AST_LATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rgb == 3'b100 && !rearm && !new_game) |=> $stable(score_bcd)); // R9
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_count < CNT_W'(WINDOW_TICKS)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == '0) |-> score_bcd == '0); // R10
endmodule

bind quiz_buzzer_ctrl quiz_buzzer_chk #(
  .N_PLAYERS(N_PLAYERS), .WINDOW_TICKS(WINDOW_TICKS),
  .SCORE_MAX(SCORE_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .buzz(buzz), .rearm(rearm),
  .new_game(new_game), .winner(winner), .status_rgb(status_rgb),
  .score_bcd(score_bcd), .win_count(win_count)
);

// File: tb/sim_quiz_buzzer_ctrl.sv
module sim_quiz_buzzer_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] buzz = '0;
  logic       rearm = 1'b0, new_game = 1'b0, inc = 1'b0, dec = 1'b0, tick = 1'b0;
  logic [3:0] winner;
  logic [2:0] status_rgb;
  logic [3:0] score_bcd;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_score [4];
  int m_win;
  bit m_late;
  int m_ticks;

  always #2 clk = ~clk;

  quiz_buzzer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .buzz(buzz), .rearm(rearm), .new_game(new_game),
    .inc(inc), .dec(dec), .tick(tick), .winner(winner),
    .status_rgb(status_rgb), .score_bcd(score_bcd)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int ew, es, ec;
    ew = (m_win < 0) ? 0 : (1 << m_win);
    es = (m_win < 0) ? 0 : m_score[m_win];
    ec = (m_win < 0) ? 2 : (m_late ? 4 : 1);
    check(tag, "winner", int'(winner), ew);
    check(tag, "score", int'(score_bcd), es);
    check(tag, "status", int'(status_rgb), ec);
  endtask

  task automatic step(input string tag, input logic [3:0] b, input logic ra,
                      input logic ng, input logic up, input logic dn, input logic tk);
    int nw;
    bit hold, grant;
    buzz = b; rearm = ra; new_game = ng; inc = up; dec = dn; tick = tk;
    hold = (m_win >= 0);
    grant = !hold && (b != 0) && !ra;
    if (ng) begin
      for (int i = 0; i < 4; i++) m_score[i] = 5;
    end else if (hold && !m_late && (up != dn)) begin
      m_score[m_win] = m_score[m_win] + (up ? 1 : -1);
      if (m_score[m_win] > 9) m_score[m_win] = 9;
      if (m_score[m_win] < 0) m_score[m_win] = 0;
    end
    if (grant || ra) begin
      m_ticks = 0; m_late = 0;
    end else if (hold && !m_late && tk) begin
      m_ticks++;
      if (m_ticks == 30) m_late = 1;
    end
    nw = m_win;
    if (ra) nw = -1;
    else if (grant) begin
      for (int i = 3; i >= 0; i--) if (b[i]) nw = i;
    end
    m_win = nw;
    @(posedge clk); #1;
    buzz = '0; rearm = 0; new_game = 0; inc = 0; dec = 0; tick = 0;
    compare_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_score[i] = 5;
    m_win = -1; m_late = 0; m_ticks = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare_all("R6_reset");

    // R2: every buzz pattern, lowest index wins; R1 lockout; R3 re-arm
    for (int p = 1; p < 16; p++) begin
      step("R2_priority", 4'(p), 0, 0, 0, 0, 0);
      step("R1_lockout", 4'hF, 0, 0, 0, 0, 0);
      step("R3_rearm", 4'h0, 1, 0, 0, 0, 0);
    end
    step("R3_buzz_with_rearm", 4'b0010, 1, 0, 0, 0, 0);

    // R4/R5: contestant 2 scoring up and down past both limits
    step("R1_grant", 4'b0100, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) step("R5_inc_sat", 0, 0, 0, 1, 0, 0);
    step("R4_both", 0, 0, 0, 1, 1, 0);
    for (int k = 0; k < 12; k++) step("R5_dec_sat", 0, 0, 0, 0, 1, 0);
    step("R4_inc", 0, 0, 0, 1, 0, 0);
    step("R10_rearm_keeps", 0, 1, 0, 0, 0, 0);
    step("R9_idle_inc", 0, 0, 0, 1, 0, 0);
    step("R9_idle_dec", 0, 0, 0, 0, 1, 0);
    step("R10_regrant", 4'b0100, 0, 0, 0, 0, 0);
    step("R3_rearm", 0, 1, 0, 0, 0, 0);

    // R8: idle ticks; R7: full window with grant-cycle tick
    for (int k = 0; k < 5; k++) step("R8_idle_tick", 0, 0, 0, 0, 0, 1);
    step("R7_grant_tick", 4'b1000, 0, 0, 0, 0, 1);
    for (int k = 0; k < 30; k++) begin
      step("R7_window", 0, 0, 0, 0, 0, 1);
      step("R7_gap", 0, 0, 0, 0, 0, 0);
    end
    step("R9_late_inc", 0, 0, 0, 1, 0, 0);
    step("R9_late_dec", 0, 0, 0, 0, 1, 0);
    step("R7_late_tick", 4'b0001, 0, 0, 0, 0, 1);
    step("R6_newgame_late", 0, 0, 1, 0, 0, 0);
    step("R3_rearm_red", 0, 1, 0, 0, 0, 0);

    // R7: window restarts from zero for a new round
    step("R7_regrant", 4'b0001, 0, 0, 0, 0, 0);
    for (int k = 0; k < 29; k++) step("R7_restart", 0, 0, 0, 0, 0, 1);
    step("R4_inc_open", 0, 0, 0, 1, 0, 0);
    step("R6_newgame_over_inc", 0, 0, 1, 1, 0, 0);
    step("R7_last", 0, 0, 0, 0, 0, 1);
    step("R3_rearm", 0, 1, 0, 0, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule